// File: doc/BRIEF.md
# Key-Protected Slow Clock Selector

This block picks the source of a low-speed timekeeping clock and models that clock as a single-cycle tick on the fast system clock. One source is an internal oscillator, presented as an enable pulse `int_en`, slowed by a programmable prescaler. The other is an external crystal, presented as an enable pulse `ext_en`, which is passed on without division. A separate gate bit decides whether the selected tick also reaches the clock output pin.

Software programs the block over a plain register bus with four word registers, selected by `addr`: 0 is source control, 1 is the prescaler, 2 is the output gate and 3 is the key-error status. The source control register is guarded. A write to it has an effect only when its upper half carries the constant 0x16AA. A write with any other value in the upper half changes nothing and sets a sticky error flag instead. Reads are combinational from `addr`. The block has no streaming data path, so the bus pins and the tick pins are plain signals with no back-pressure.

Top module: `slow_clk_sel`

## Requirements
- R1: After reset, the internal source is selected, the prescale value is 0, the gate is off and the key-error flag is clear. Every register then reads 0, and `gate_en` and `out_tick` are 0.
- R2: A write to address 0 with bits 31:16 equal to 0x16AA loads bit 0 as the source select. A value of 1 selects the external source and 0 selects the internal one.
- R3: A write to address 0 whose bits 31:16 differ from 0x16AA leaves the source select unchanged. The next cycle, it sets the key-error flag, which reads back at bit 0 of address 3.
- R4: The key-error flag stays set until a write to address 3 with bit 0 equal to 1 clears it. A write to address 3 needs no key.
- R5: A read of address 0 returns the source select in bit 0 and zero in all other bits, including the key field.
- R6: While the internal source is selected with prescale value P, `slow_tick` pulses for one cycle for every P+1 `int_en` pulses counted since the last restart. The pulse appears in the cycle after the enable that completes the count.
- R7: While the external source is selected, `slow_tick` equals `ext_en` delayed by one cycle. The prescaler and `int_en` have no effect on it.
- R8: The divider count restarts from zero when a write changes the prescale value or the source select. A write that leaves both values as they were does not restart it.
- R9: Bit 0 of address 2 is the output gate and drives `gate_en`. `out_tick` equals `slow_tick` when the gate is 1 and is 0 when the gate is 0.
- R10: Address 1 holds the prescale value in bits 4:0 and reads zero in bits 31:5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr | input | 1 | Register write strobe |
| addr | input | 2 | Register address (0 control, 1 prescale, 2 gate, 3 status) |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` |
| int_en | input | 1 | Internal oscillator enable pulse |
| ext_en | input | 1 | External crystal enable pulse |
| slow_tick | output | 1 | Selected slow clock tick |
| out_tick | output | 1 | Tick driven to the gated clock output |
| gate_en | output | 1 | Output gate enable |

## Verification
The divider is driven with random `int_en` trains under prescale values 0, 1, 5, 31 and random values. A value of 0 shows that every enable passes straight through. A value of 31 exercises the full width of the field. The random values catch off-by-one errors in the terminal count. A train is broken mid-count by writes that change the prescale value and by writes that rewrite it unchanged, which separates a correct restart from a missing or spurious one. Random `ext_en` is applied in external mode while `int_en` keeps toggling, to show the prescaler is bypassed. Control writes with the correct key and with wrong keys show whether the key check guards the source select, and gate-off windows show that the output pin is masked while `slow_tick` still pulses.

// File: rtl/slck_pkg.sv
package slck_pkg;
  localparam int unsigned DW       = 32;
  localparam int unsigned AW       = 2;
  localparam int unsigned KEY_W    = 16;
  localparam logic [KEY_W-1:0] UNLOCK_KEY = 16'h16AA;

  typedef enum logic [AW-1:0] {
    REG_SRC    = 2'd0,
    REG_PRESC  = 2'd1,
    REG_GATE   = 2'd2,
    REG_STATUS = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/slck_regs.sv
module slck_regs
  import slck_pkg::*;
#(
  parameter int unsigned PW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          src_ext,
  output logic [PW-1:0] presc,
  output logic          gate,
  output logic          key_err,
  output logic          restart
);
  logic key_ok, src_wr, presc_wr, gate_wr, stat_wr;

  always_comb begin
    key_ok   = (wdata[DW-1 -: KEY_W] == UNLOCK_KEY);
    src_wr   = wr && (addr == REG_SRC);
    presc_wr = wr && (addr == REG_PRESC);
    gate_wr  = wr && (addr == REG_GATE);
    stat_wr  = wr && (addr == REG_STATUS);
    restart  = (src_wr && key_ok && (wdata[0] != src_ext)) ||
               (presc_wr && (wdata[PW-1:0] != presc));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_ext <= 1'b0;
      presc   <= '0;
      gate    <= 1'b0;
      key_err <= 1'b0;
    end else begin
      if (src_wr && key_ok) src_ext <= wdata[0];
      if (presc_wr)         presc   <= wdata[PW-1:0];
      if (gate_wr)          gate    <= wdata[0];
      if (src_wr && !key_ok)            key_err <= 1'b1;
      else if (stat_wr && wdata[0])     key_err <= 1'b0;
    end
  end

  always_comb begin
    rdata = '0;
    unique case (addr)
      REG_SRC:    rdata[0]    = src_ext;
      REG_PRESC:  rdata[PW-1:0] = presc;
      REG_GATE:   rdata[0]    = gate;
      REG_STATUS: rdata[0]    = key_err;
      default:    rdata       = '0;
    endcase
  end
endmodule

// File: rtl/slck_div.sv
module slck_div #(
  parameter int unsigned PW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          restart,
  input  logic [PW-1:0] presc,
  output logic          tick
);
  logic [PW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (restart) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (en) begin
      if (cnt == presc) begin
        cnt  <= '0;
        tick <= 1'b1;
      end else begin
        cnt  <= cnt + 1'b1;
        tick <= 1'b0;
      end
    end else begin
      tick <= 1'b0;
    end
  end
endmodule

// File: rtl/slck_mux.sv
module slck_mux (
  input  logic clk,
  input  logic rst_n,
  input  logic ext_en,
  input  logic restart,
  input  logic src_ext,
  input  logic div_tick,
  input  logic gate,
  output logic slow_tick,
  output logic out_tick
);
  logic ext_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ext_q <= 1'b0;
    else if (restart) ext_q <= 1'b0;
    else              ext_q <= ext_en;
  end

  always_comb begin
    slow_tick = src_ext ? ext_q : div_tick;
    out_tick  = slow_tick & gate;
  end
endmodule

// File: rtl/slow_clk_sel.sv
module slow_clk_sel
  import slck_pkg::*;
#(
  parameter int unsigned PW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic          int_en,
  input  logic          ext_en,
  output logic          slow_tick,
  output logic          out_tick,
  output logic          gate_en
);
  logic          src_q, gate_q, key_err_q, restart, div_tick;
  logic [PW-1:0] presc_q;

  slck_regs #(.PW(PW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(wr), .addr(addr), .wdata(wdata),
    .rdata(rdata), .src_ext(src_q), .presc(presc_q), .gate(gate_q),
    .key_err(key_err_q), .restart(restart)
  );

  slck_div #(.PW(PW)) u_div (
    .clk(clk), .rst_n(rst_n), .en(int_en & ~src_q), .restart(restart),
    .presc(presc_q), .tick(div_tick)
  );

  slck_mux u_mux (
    .clk(clk), .rst_n(rst_n), .ext_en(ext_en), .restart(restart),
    .src_ext(src_q), .div_tick(div_tick), .gate(gate_q),
    .slow_tick(slow_tick), .out_tick(out_tick)
  );

  assign gate_en = gate_q;
endmodule

// File: rtl/slck_checker.sv
module slck_checker
  import slck_pkg::*;
(
  input logic          clk,
  input logic          rst_n,
  input logic          wr,
  input logic [AW-1:0] addr,
  input logic [DW-1:0] wdata,
  input logic [DW-1:0] rdata,
  input logic          int_en,
  input logic          ext_en,
  input logic          src,
  input logic          key_err,
  input logic          slow_tick,
  input logic          out_tick,
  input logic          gate_en
);
  logic bad_key_wr;
  assign bad_key_wr = wr && (addr == REG_SRC) && (wdata[DW-1 -: KEY_W] != UNLOCK_KEY);

  AST_BAD_KEY_HOLDS_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    bad_key_wr |=> $stable(src)); // R3
  AST_BAD_KEY_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    bad_key_wr |=> key_err); // R3
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (key_err && !(wr && addr == REG_STATUS && wdata[0])) |=> key_err); // R4
  AST_KEY_FIELD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == REG_SRC) |-> (rdata[DW-1:1] == '0)); // R5
  AST_INT_TICK_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    (slow_tick && !src && $past(rst_n) && $past(!src)) |-> $past(int_en)); // R6
  AST_EXT_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && src && $past(src) && !$past(wr)) |-> (slow_tick == $past(ext_en))); // R7
  AST_GATE_MASKS: assert property (@(posedge clk) disable iff (!rst_n)
    !gate_en |-> !out_tick); // R9
endmodule

bind slow_clk_sel slck_checker u_chk (
  .clk(clk), .rst_n(rst_n), .wr(wr), .addr(addr), .wdata(wdata),
  .rdata(rdata), .int_en(int_en), .ext_en(ext_en), .src(src_q),
  .key_err(key_err_q), .slow_tick(slow_tick), .out_tick(out_tick),
  .gate_en(gate_en)
);

// File: tb/slow_clk_sel_bench.sv
`timescale 1ns/1ps
module slow_clk_sel_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        int_en = 1'b0, ext_en = 1'b0;
  logic        slow_tick, out_tick, gate_en;

  int n_chk = 0, n_fail = 0;
  int cur_p = 0;      // model prescale value
  int cnt_m = 0;      // model enables since restart
  bit src_m = 0, gate_m = 0;
  bit exp_tick = 0;

  always #5 clk = ~clk;

  slow_clk_sel u_slow_clk_sel (
    .clk(clk), .rst_n(rst_n), .wr(wr), .addr(addr), .wdata(wdata),
    .rdata(rdata), .int_en(int_en), .ext_en(ext_en),
    .slow_tick(slow_tick), .out_tick(out_tick), .gate_en(gate_en)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic reg_wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    int_en = 0; ext_en = 0;
    wr = 1; addr = a; wdata = d;
    @(negedge clk);
    wr = 0;
  endtask

  task automatic reg_rd(input logic [1:0] a, input logic [31:0] exp, input string req);
    addr = a; #1;
    chk(rdata === exp, req, rdata, exp);
  endtask

  // Model of the divider tick for an enable driven now (R6)
  function automatic bit int_step(input bit en);
    if (!en) return 0;
    if (cnt_m == cur_p) begin cnt_m = 0; return 1; end
    cnt_m++;
    return 0;
  endfunction

  task automatic set_presc(input int p);
    if (p != cur_p) cnt_m = 0;   // R8: restart only on a change
    cur_p = p;
    reg_wr(2'd1, 32'hFFFF_FFE0 | p);
    reg_rd(2'd1, p, "R10 prescale readback");
  endtask

  task automatic run(input int cycles, input int dens);
    exp_tick = 0;
    for (int i = 0; i < cycles; i++) begin
      bit ie, ee;
      @(negedge clk);
      #1;
      chk(slow_tick === exp_tick, src_m ? "R7 external tick" : "R6 divided tick", slow_tick, exp_tick);
      chk(out_tick === (exp_tick & gate_m), "R9 gated output", out_tick, exp_tick & gate_m);
      ie = ($urandom % 100) < dens;
      ee = ($urandom % 100) < dens;
      int_en = ie; ext_en = ee;
      if (src_m) exp_tick = ee;
      else       exp_tick = int_step(ie);
    end
    @(negedge clk);
    int_en = 0; ext_en = 0;
  endtask

  initial begin
    int wd = 0;
    forever begin
      @(posedge clk);
      wd++;
      if (wd > 150000) begin
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    reg_rd(2'd0, 0, "R1 source reset");
    reg_rd(2'd1, 0, "R1 prescale reset");
    reg_rd(2'd2, 0, "R1 gate reset");
    reg_rd(2'd3, 0, "R1 key error reset");
    chk(gate_en === 0, "R1 gate_en reset", gate_en, 0);
    chk(out_tick === 0, "R1 out_tick reset", out_tick, 0);

    // R2 keyed write, R5 readback key field
    reg_wr(2'd0, 32'h16AA_0001); src_m = 1;
    reg_rd(2'd0, 32'h1, "R2 R5 keyed select external");
    // R3 wrong keys
    reg_wr(2'd0, 32'h1234_0000);
    reg_rd(2'd0, 32'h1, "R3 bad key ignored");
    reg_rd(2'd3, 32'h1, "R3 key error set");
    reg_wr(2'd0, 32'h16AB_0000);
    reg_rd(2'd0, 32'h1, "R3 near key ignored");
    // R4 sticky then clear
    reg_wr(2'd3, 32'h0);
    reg_rd(2'd3, 32'h1, "R4 sticky on zero write");
    reg_wr(2'd3, 32'h1);
    reg_rd(2'd3, 32'h0, "R4 cleared");

    // R9 gate on, R7 external mode with toggling int_en
    reg_wr(2'd2, 32'h1); gate_m = 1;
    reg_rd(2'd2, 32'h1, "R9 gate readback");
    chk(gate_en === 1, "R9 gate_en", gate_en, 1);
    set_presc(7);
    run(200, 50);

    // back to internal, R6 several prescales
    reg_wr(2'd0, 32'h16AA_0000); src_m = 0; cnt_m = 0;
    reg_rd(2'd0, 32'h0, "R2 keyed select internal");
    set_presc(0);  run(100, 60);
    set_presc(1);  run(200, 70);
    set_presc(31); run(600, 90);
    // R8: same value rewritten keeps count, new value restarts
    set_presc(5);  run(13, 80);
    set_presc(5);  run(40, 80);
    set_presc(4);  run(40, 80);
    // R9 gate off while ticking
    reg_wr(2'd2, 32'h0); gate_m = 0;
    chk(gate_en === 0, "R9 gate_en off", gate_en, 0);
    run(100, 80);
    reg_wr(2'd2, 32'h1); gate_m = 1;
    for (int k = 0; k < 6; k++) begin
      set_presc($urandom % 32);
      run(150, 30 + ($urandom % 70));
    end
    // R8: source switch mid-count
    reg_wr(2'd0, 32'h16AA_0001); src_m = 1;
    run(50, 50);
    reg_wr(2'd0, 32'h16AA_0000); src_m = 0; cnt_m = 0;
    run(200, 60);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule